// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block evaluates a set of Boolean functions in two programmable planes. The first plane forms a fixed number of product terms from the inputs. In each term, every input can appear true, appear complemented, be left out, or force the whole term to zero. The second plane forms each output as the OR of any chosen subset of those terms. A term can feed any number of outputs, so terms shared between functions are built only once. A full decoder would build all 2^k minterms; this block builds only the product terms that are actually needed.

A synchronous configuration port loads one plane row per clock edge. Once the planes are loaded, the outputs follow the inputs through combinational logic only. The block then acts like a 2^k-word by n-bit read-only table. A table can be realized only if each of its functions fits within the available product terms. The default size is 3 inputs, 4 product terms and 3 outputs.

Top module: `pla_top`

## Requirements
- R1: While reset is held, and after reset before any write, plaOut is all zeros for every input value, because reset clears both planes.
- R2: Each term row holds 2 bits per input, with input i at bits [2i+1:2i]. The codes are 00 = input not used, 01 = term needs the input at 1, 10 = term needs the input at 0, and 11 = term is forced to 0.
- R3: A term whose row is all 00 evaluates to 1, so any output connected to it is 1 for every input value.
- R4: An output whose OR-plane mask is zero is 0 for every input value.
- R5: Output o equals the OR of the terms t whose bit t is set in the mask of output o. One term may be set in the masks of several outputs.
- R6: A write with cfgWe high changes a plane on the rising clock edge and not before. With cfgWe low, no plane changes.
- R7: cfgAddr has one plane-select bit at the top and an index in the bits below it. A select of 0 loads cfgData[2*IN_W-1:0] into the row of term index. A select of 1 loads cfgData[TERMS-1:0] into the mask of output index. A write whose index is past the last term or output is ignored.
- R8: plaOut depends only on plaIn and the current plane contents. It follows a change of plaIn with no clock edge.
- R9: With terms x·y'·z', x'·z, x'·y·z' and x·y (x = plaIn[2], z = plaIn[0]) and masks out2 = {t0,t1,t2}, out1 = {t2,t3}, out0 = {t0,t3}, the outputs are out2 = Σm(1,2,3,4), out1 = Σm(2,6,7) and out0 = Σm(4,6,7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Asynchronous active-low reset; clears both planes |
| cfgWe | input | 1 | Write enable for the configuration port |
| cfgAddr | input | IDX_W+1 | Plane select (top bit) and row index |
| cfgData | input | max(2*IN_W, TERMS) | Row contents to write |
| plaIn | input | IN_W | Function inputs |
| plaOut | output | OUT_W | Function outputs |

## Verification
The block keeps no state other than the two planes, so any corrupted plane bit shows up at plaOut within the same cycle. It appears for every input value that the affected term covers. If a row is written into the wrong place, or a write lands on the wrong edge, an output bit is wrong in the first cycle after that edge. Sweeping every input value after each write therefore exposes a corrupted row at once. Checking the outputs just before each edge shows whether a write took effect early.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int IDX_MAX = 8;

  typedef struct packed {
    logic               andWr;
    logic               orWr;
    logic [IDX_MAX-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/pla_ctrl.sv
module pla_ctrl
  import pla_pkg::*;
#(
  parameter int TERMS = 4,
  parameter int OUT_W = 3,
  parameter int IDX_W = 2
) (
  input  logic             cfgWe,
  input  logic [IDX_W:0]   cfgAddr,
  output cfgStrobe_t       strobe
);
  logic [IDX_W-1:0] rowIdx;
  logic             selOr;

  assign rowIdx = cfgAddr[IDX_W-1:0];
  assign selOr  = cfgAddr[IDX_W];

  always_comb begin
    strobe.andWr = cfgWe && !selOr && (32'(rowIdx) < TERMS);
    strobe.orWr  = cfgWe &&  selOr && (32'(rowIdx) < OUT_W);
    strobe.idx   = IDX_MAX'(rowIdx);
  end
endmodule

// File: rtl/pla_planes.sv
module pla_planes
  import pla_pkg::*;
#(
  parameter int IN_W   = 3,
  parameter int TERMS  = 4,
  parameter int OUT_W  = 3,
  parameter int DATA_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                strobe,
  input  logic [DATA_W-1:0]         cfgData,
  output logic [TERMS*2*IN_W-1:0]   andPlane,
  output logic [OUT_W*TERMS-1:0]    orPlane
);
  localparam int ROW_W = 2 * IN_W;

  for (genvar t = 0; t < TERMS; t++) begin : g_andRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        andPlane[t*ROW_W +: ROW_W] <= '0;
      end else if (strobe.andWr && strobe.idx == IDX_MAX'(t)) begin
        andPlane[t*ROW_W +: ROW_W] <= cfgData[ROW_W-1:0];
      end
    end
  end

  for (genvar o = 0; o < OUT_W; o++) begin : g_orRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        orPlane[o*TERMS +: TERMS] <= '0;
      end else if (strobe.orWr && strobe.idx == IDX_MAX'(o)) begin
        orPlane[o*TERMS +: TERMS] <= cfgData[TERMS-1:0];
      end
    end
  end
endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int IN_W  = 3,
  parameter int TERMS = 4,
  parameter int OUT_W = 3
) (
  input  logic [IN_W-1:0]         plaIn,
  input  logic [TERMS*2*IN_W-1:0] andPlane,
  input  logic [OUT_W*TERMS-1:0]  orPlane,
  output logic [OUT_W-1:0]        plaOut
);
  localparam int ROW_W = 2 * IN_W;

  logic [TERMS-1:0] termVal;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic [IN_W-1:0] litOk;
    for (genvar i = 0; i < IN_W; i++) begin : g_lit
      logic [1:0] code;
      assign code = andPlane[t*ROW_W + 2*i +: 2];
      always_comb begin
        unique case (code)
          2'b00:   litOk[i] = 1'b1;
          2'b01:   litOk[i] = plaIn[i];
          2'b10:   litOk[i] = ~plaIn[i];
          default: litOk[i] = 1'b0;
        endcase
      end
    end
    assign termVal[t] = &litOk;
  end

  for (genvar o = 0; o < OUT_W; o++) begin : g_out
    assign plaOut[o] = |(orPlane[o*TERMS +: TERMS] & termVal);
  end
endmodule

// File: rtl/pla_top.sv
module pla_top
  import pla_pkg::*;
#(
  parameter int IN_W  = 3,
  parameter int TERMS = 4,
  parameter int OUT_W = 3,
  localparam int MAX_ROWS = (TERMS > OUT_W) ? TERMS : OUT_W,
  localparam int IDX_W    = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1,
  localparam int DATA_W   = (2*IN_W > TERMS) ? 2*IN_W : TERMS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W:0]    cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [IN_W-1:0]   plaIn,
  output logic [OUT_W-1:0]  plaOut
);
  cfgStrobe_t                strobe;
  logic [TERMS*2*IN_W-1:0]   andPlane;
  logic [OUT_W*TERMS-1:0]    orPlane;

  pla_ctrl #(.TERMS(TERMS), .OUT_W(OUT_W), .IDX_W(IDX_W)) u_ctrl (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .strobe (strobe)
  );

  pla_planes #(.IN_W(IN_W), .TERMS(TERMS), .OUT_W(OUT_W), .DATA_W(DATA_W)) u_planes (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .andPlane(andPlane),
    .orPlane (orPlane)
  );

  pla_eval #(.IN_W(IN_W), .TERMS(TERMS), .OUT_W(OUT_W)) u_eval (
    .plaIn   (plaIn),
    .andPlane(andPlane),
    .orPlane (orPlane),
    .plaOut  (plaOut)
  );
endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
  parameter int IN_W   = 3,
  parameter int TERMS  = 4,
  parameter int OUT_W  = 3,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cfgWe,
  input logic [IDX_W:0]          cfgAddr,
  input logic [DATA_W-1:0]       cfgData,
  input logic [IN_W-1:0]         plaIn,
  input logic [OUT_W-1:0]        plaOut,
  input logic [TERMS*2*IN_W-1:0] andPlane,
  input logic [OUT_W*TERMS-1:0]  orPlane
);
  localparam int ROW_W = 2 * IN_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> plaOut == '0);

  assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe ##1 $stable(plaIn) |-> $stable(plaOut));

  for (genvar o = 0; o < OUT_W; o++) begin : g_outChk
    assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
      orPlane[o*TERMS +: TERMS] == '0 |-> !plaOut[o]);

    assert_or_write_R7: assert property (@(posedge clk) disable iff (!rstN)
      cfgWe && cfgAddr == {1'b1, IDX_W'(o)} |=> orPlane[o*TERMS +: TERMS] == $past(cfgData[TERMS-1:0]));

    for (genvar t = 0; t < TERMS; t++) begin : g_termChk
      assert_free_term_R3: assert property (@(posedge clk) disable iff (!rstN)
        andPlane[t*ROW_W +: ROW_W] == '0 && orPlane[o*TERMS + t] |-> plaOut[o]);
    end
  end

  for (genvar t = 0; t < TERMS; t++) begin : g_andChk
    assert_and_write_R6: assert property (@(posedge clk) disable iff (!rstN)
      cfgWe && cfgAddr == {1'b0, IDX_W'(t)} |=> andPlane[t*ROW_W +: ROW_W] == $past(cfgData[ROW_W-1:0]));
  end
endmodule

bind pla_top pla_checker #(
  .IN_W(IN_W), .TERMS(TERMS), .OUT_W(OUT_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWe   (cfgWe),
  .cfgAddr (cfgAddr),
  .cfgData (cfgData),
  .plaIn   (plaIn),
  .plaOut  (plaOut),
  .andPlane(andPlane),
  .orPlane (orPlane)
);

// File: tb/pla_top_tb.sv
module pla_top_tb;
  localparam int IN_W  = 3;
  localparam int TERMS = 4;
  localparam int OUT_W = 3;
  localparam int IDX_W = 2;
  localparam int DATA_W = 6;
  localparam int NVEC = 1 << IN_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cfgWe;
  logic [IDX_W:0]    cfgAddr;
  logic [DATA_W-1:0] cfgData;
  logic [IN_W-1:0]   plaIn;
  logic [OUT_W-1:0]  plaOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int andCode [TERMS][IN_W];
  int orMask  [OUT_W];

  always #10 clk = ~clk;

  pla_top #(.IN_W(IN_W), .TERMS(TERMS), .OUT_W(OUT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .plaIn(plaIn), .plaOut(plaOut)
  );

  function automatic logic [OUT_W-1:0] modelOut(int v);
    logic [OUT_W-1:0] res = '0;
    for (int o = 0; o < OUT_W; o++) begin
      for (int t = 0; t < TERMS; t++) begin
        if (((orMask[o] >> t) & 1) == 1) begin
          bit term = 1;
          for (int i = 0; i < IN_W; i++) begin
            int b = (v >> i) & 1;
            case (andCode[t][i])
              1: if (b == 0) term = 0;
              2: if (b == 1) term = 0;
              3: term = 0;
              default: ;
            endcase
          end
          if (term) res[o] = 1'b1;
        end
      end
    end
    return res;
  endfunction

  task automatic check(string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp, int v);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s in=%0d actual=%b expected=%b", req, v, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      plaIn = IN_W'(v);
      #1 check(req, plaOut, modelOut(v), v);
    end
  endtask

  // R6/R7: drive a write; outputs must still match the old model before the edge
  task automatic cfgWrite(logic [IDX_W:0] addr, logic [DATA_W-1:0] data, bit we);
    int idx;
    @(negedge clk);
    cfgWe = we; cfgAddr = addr; cfgData = data;
    #1 check("R6 pre-edge", plaOut, modelOut(int'(plaIn)), int'(plaIn));
    @(posedge clk);
    idx = int'(addr[IDX_W-1:0]);
    if (we) begin
      if (!addr[IDX_W] && idx < TERMS) begin
        for (int i = 0; i < IN_W; i++) andCode[idx][i] = int'(data[2*i +: 2]);
      end else if (addr[IDX_W] && idx < OUT_W) begin
        orMask[idx] = int'(data[TERMS-1:0]);
      end
    end
    #1 cfgWe = 1'b0;
  endtask

  function automatic bit inList(int v, int a, int b, int c, int d);
    return v == a || v == b || v == c || v == d;
  endfunction

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < TERMS; t++) for (int i = 0; i < IN_W; i++) andCode[t][i] = 0;
    for (int o = 0; o < OUT_W; o++) orMask[o] = 0;
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; plaIn = '0;

    // R1: during reset and right after it
    repeat (2) @(negedge clk);
    #1 check("R1 in reset", plaOut, '0, 0);
    @(negedge clk) rstN = 1'b1;
    sweep("R1");

    // R4: terms all free but no masks set
    sweep("R4 empty masks");

    // R3: free term connected to out0 only
    cfgWrite({1'b1, 2'd0}, 6'b0001, 1'b1);
    sweep("R3 free term");
    check("R3 out0 high", plaOut, 3'b001, int'(plaIn));

    // R9, R5, R2: shared-term example, x=in2 y=in1 z=in0
    cfgWrite({1'b0, 2'd0}, 6'b01_10_10, 1'b1);
    cfgWrite({1'b0, 2'd1}, 6'b10_00_01, 1'b1);
    cfgWrite({1'b0, 2'd2}, 6'b10_01_10, 1'b1);
    cfgWrite({1'b0, 2'd3}, 6'b01_01_00, 1'b1);
    cfgWrite({1'b1, 2'd2}, 6'b0111, 1'b1);
    cfgWrite({1'b1, 2'd1}, 6'b1100, 1'b1);
    cfgWrite({1'b1, 2'd0}, 6'b1001, 1'b1);
    sweep("R5 shared terms");
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] exp;
      @(negedge clk);
      plaIn = 3'(v);
      exp[2] = inList(v, 1, 2, 3, 4);
      exp[1] = inList(v, 2, 6, 7, -1);
      exp[0] = inList(v, 4, 6, 7, -1);
      #1 check("R9 minterm lists", plaOut, exp, v);
    end

    // R8: input change between edges, no clock
    @(negedge clk);
    plaIn = 3'd6;
    #1 check("R8 settle a", plaOut, 3'b011, 6);
    plaIn = 3'd1;
    #1 check("R8 settle b", plaOut, 3'b100, 1);

    // R2: kill code 11 on term3 input0
    cfgWrite({1'b0, 2'd3}, 6'b01_01_11, 1'b1);
    sweep("R2 kill code");

    // R6: write with enable low ignored
    cfgWrite({1'b1, 2'd0}, 6'b1111, 1'b0);
    sweep("R6 no enable");

    // R7: OR index past last output ignored
    cfgWrite({1'b1, 2'd3}, 6'b1111, 1'b1);
    sweep("R7 out-of-range");

    // R5/R2: random programs
    for (int k = 0; k < 12; k++) begin
      for (int t = 0; t < TERMS; t++) cfgWrite({1'b0, 2'(t)}, 6'($urandom), 1'b1);
      for (int o = 0; o < OUT_W; o++) cfgWrite({1'b1, 2'(o)}, 6'($urandom), 1'b1);
      sweep("R5 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule